// File: doc/BRIEF.md
# Gated-Row Array Multiplier

This block multiplies an 8-bit unsigned multiplicand by a 4-bit unsigned multiplier using only combinational logic. There is no clock, reset or handshake. Results follow the operands after the propagation delay of the array.

The array is a stack of ripple-carry adder rows, one row for each multiplier bit, starting with the least significant bit. In each row, every multiplicand bit is ANDed with that row's multiplier bit before it enters a full adder. The other adder operand is the previous row's result, shifted right by one place: the row's carry-out becomes its top bit, and its lowest sum bit leaves the row as a finished product bit. The first row adds to zero.

Two results are produced. One is the complete 12-bit product. The other is a reduced result that holds only the eight most significant product bits. That reduced result suits datapaths that keep a fixed-width scaled value.

Top module: `gated_array_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals `op_a * op_b` as a 12-bit unsigned value.
- R2: `prod_hi` always equals `prod[11:4]`, the eight most significant product bits.
- R3: When `op_b` is zero, every row is gated off and `prod` is 0 for any `op_a`.
- R4: When `op_a` is zero, `prod` is 0 for any `op_b`.
- R5: When `op_b` has exactly one bit set at position k, `prod` equals `op_a` shifted left by k, and the product bits below k are zero.
- R6: The largest operands, 255 and 15, give `prod` = 12'hEF1 and `prod_hi` = 8'hEF. The final carry out of the last row lands in bit 11.
- R7: When `op_b` is 4'hF, `prod` equals `(op_a << 4) - op_a`, so the carry chain crosses every row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Unsigned multiplicand, bit 0 least significant |
| op_b | input | 4 | Unsigned multiplier; bit i gates row i |
| prod | output | 12 | Full unsigned product |
| prod_hi | output | 8 | Product bits 11 down to 4 |

## Verification
The checker watches the outputs whenever the operands settle. It checks the arithmetic identity, the slice relation between the two outputs, the zero-operand cases and the single-bit multiplier case. The bench goes further and walks all 4096 operand pairs against a product it computes itself. Only that sweep, together with the directed vectors for the largest operands and the all-ones multiplier, shows that each row's carry reaches the correct column of the next row.

// File: rtl/gam_pkg.sv
package gam_pkg;
  localparam int unsigned MCAND_W = 8;
  localparam int unsigned MPLR_W  = 4;
  localparam int unsigned PROD_W  = MCAND_W + MPLR_W;
endpackage

// File: rtl/gam_gated_cell.sv
module gam_gated_cell (
  input  logic mcand_bit,
  input  logic gate,
  input  logic acc_bit,
  input  logic cin,
  output logic sum,
  output logic cout
);
  logic masked;

  always_comb begin
    masked = mcand_bit & gate;
    sum    = masked ^ acc_bit ^ cin;
    cout   = (masked & acc_bit) | (cin & (masked ^ acc_bit));
  end
endmodule

// File: rtl/gam_gated_row.sv
module gam_gated_row #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] mcand,
  input  logic             gate,
  input  logic [WIDTH-1:0] acc_in,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH:0] carry;

  assign carry[0] = 1'b0;

  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    gam_gated_cell u_cell (
      .mcand_bit (mcand[k]),
      .gate      (gate),
      .acc_bit   (acc_in[k]),
      .cin       (carry[k]),
      .sum       (sum[k]),
      .cout      (carry[k+1])
    );
  end

  assign cout = carry[WIDTH];
endmodule

// File: rtl/gated_array_mult.sv
module gated_array_mult #(
  parameter int unsigned MCAND_W = gam_pkg::MCAND_W,
  parameter int unsigned MPLR_W  = gam_pkg::MPLR_W
) (
  input  logic [MCAND_W-1:0]        op_a,
  input  logic [MPLR_W-1:0]         op_b,
  output logic [MCAND_W+MPLR_W-1:0] prod,
  output logic [MCAND_W-1:0]        prod_hi
);
  localparam int unsigned PW = MCAND_W + MPLR_W;

  // acc[r] is the second operand of row r; acc[0] is zero
  logic [MCAND_W-1:0] acc  [MPLR_W+1];
  logic [MCAND_W-1:0] rsum [MPLR_W];
  logic [MPLR_W-1:0]  rcout;
  logic [MPLR_W-1:0]  low_bits;

  assign acc[0] = '0;

  for (genvar r = 0; r < MPLR_W; r++) begin : g_row
    gam_gated_row #(.WIDTH(MCAND_W)) u_row (
      .mcand  (op_a),
      .gate   (op_b[r]),
      .acc_in (acc[r]),
      .sum    (rsum[r]),
      .cout   (rcout[r])
    );
    // lowest sum bit retires; carry-out enters at the top
    assign low_bits[r] = rsum[r][0];
    assign acc[r+1]    = {rcout[r], rsum[r][MCAND_W-1:1]};
  end

  assign prod    = {acc[MPLR_W], low_bits};
  assign prod_hi = prod[PW-1:MPLR_W];
endmodule

// File: rtl/gam_checker.sv
module gam_checker #(
  parameter int unsigned MCAND_W = 8,
  parameter int unsigned MPLR_W  = 4
) (
  input logic [MCAND_W-1:0]        op_a,
  input logic [MPLR_W-1:0]         op_b,
  input logic [MCAND_W+MPLR_W-1:0] prod,
  input logic [MCAND_W-1:0]        prod_hi
);
  localparam int unsigned PW = MCAND_W + MPLR_W;
  logic [PW-1:0] wide_a;
  logic [PW-1:0] wide_b;

  always_comb begin
    wide_a = PW'(op_a);
    wide_b = PW'(op_b);
    a_r1_product_exact: assert (prod == PW'(wide_a * wide_b));
    a_r2_high_slice: assert (prod_hi == prod[PW-1:MPLR_W]);
    if (op_b == '0) begin
      a_r3_zero_multiplier: assert (prod == '0);
    end
    if (op_a == '0) begin
      a_r4_zero_multiplicand: assert (prod == '0);
    end
    if ($countones(op_b) == 1) begin
      a_r5_onehot_shift: assert (prod == PW'(wide_a * wide_b));
    end
  end
endmodule

bind gated_array_mult gam_checker #(
  .MCAND_W (MCAND_W),
  .MPLR_W  (MPLR_W)
) u_gam_checker (
  .op_a    (op_a),
  .op_b    (op_b),
  .prod    (prod),
  .prod_hi (prod_hi)
);

// File: tb/test_gated_array_mult.sv
`timescale 1ns/1ps
module test_gated_array_mult;
  logic clk = 1'b0;
  logic [7:0]  op_a;
  logic [3:0]  op_b;
  logic [11:0] prod;
  logic [7:0]  prod_hi;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gated_array_mult i_gated_array_mult (
    .op_a(op_a), .op_b(op_b), .prod(prod), .prod_hi(prod_hi)
  );

  // {a, b, expected product}
  localparam logic [23:0] VEC [12] = '{
    {8'h00, 4'h0, 12'h000}, {8'hFF, 4'hF, 12'hEF1},
    {8'h01, 4'h1, 12'h001}, {8'h80, 4'h8, 12'h400},
    {8'hAA, 4'h5, 12'h352}, {8'h55, 4'hA, 12'h352},
    {8'h0F, 4'h3, 12'h02D}, {8'hC3, 4'h7, 12'h555},
    {8'h12, 4'h9, 12'h0A2}, {8'hFF, 4'h1, 12'h0FF},
    {8'h01, 4'hF, 12'h00F}, {8'h64, 4'hC, 12'h4B0}
  };

  task automatic apply(input logic [7:0] a, input logic [3:0] b);
    @(posedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, op_a, op_b, act, exp);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    op_a = '0; op_b = '0;
    @(negedge clk);
    chk("R4 idle", prod, 12'h000);

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][23:16], VEC[i][15:12]);
      chk("R1 table", prod, VEC[i][11:0]);
      chk("R2 table", {4'h0, prod_hi}, {4'h0, VEC[i][11:4]});
    end

    // exhaustive sweep, grouped by multiplier per clock
    for (int b = 0; b < 16; b++) begin
      for (int a = 0; a < 256; a++) begin
        logic [11:0] exp;
        op_a = 8'(a);
        op_b = 4'(b);
        #0.01;
        exp = 12'(a * b);
        chk("R1 sweep", prod, exp);
        chk("R2 sweep", {4'h0, prod_hi}, {4'h0, exp[11:4]});
      end
      @(negedge clk);
    end

    apply(8'hFF, 4'hF);
    chk("R6 max product", prod, 12'hEF1);
    chk("R6 max high", {4'h0, prod_hi}, 12'h0EF);

    apply(8'h9D, 4'h0);
    chk("R3 zero b", prod, 12'h000);
    apply(8'h00, 4'hB);
    chk("R4 zero a", prod, 12'h000);

    for (int k = 0; k < 4; k++) begin
      apply(8'hB7, 4'(1 << k));
      chk("R5 onehot", prod, 12'(12'h0B7 << k));
    end

    apply(8'h6E, 4'hF);
    chk("R7 all ones", prod, 12'((12'h6E << 4) - 12'h6E));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule